// File: doc/BRIEF.md
# Double-Buffered Asynchronous Serial Transmitter

This block serialises bytes onto a single output line in asynchronous frame format. The host writes a byte into a holding register and then hands it over by clearing the empty flag. The engine copies the byte into its private shift register and sets the empty flag again, so the host can stage the next byte while the current frame is still going out. Each bit lasts one period of an external bit-rate enable pulse. The host sets the frame format through static controls: 7 or 8 data bits, an optional parity or address-marker bit, and one or two stop bits.

At the moment the stop bit begins, the engine checks the empty flag. If a new byte is waiting, it reloads the shift register and starts the next frame straight after the stop field, with no idle bit in between. If nothing is waiting, it sets the transmit-end flag and leaves the line in the mark state (held at 1). Two level interrupt outputs, each gated by its own enable, report "holding register free" and "transmission finished".

Top module: `sertx_top`

## Requirements
- R1: While reset is held, and once it is released, `txd` is 1, `empty_flag` is 1 and `end_flag` is 1. Both interrupt outputs are 0 while their enables are 0.
- R2: When `empty_flag` is 0 and the engine is idle, the engine copies the holding register into the shift register on the next clock and sets `empty_flag` back to 1. This happens before the start bit appears.
- R3: A frame begins with one 0 start bit. The data bits follow with the least significant bit first. There are 8 data bits when `fmt_len7`=0, and bits 0..6 only when `fmt_len7`=1.
- R4: An extra bit follows the data. When `fmt_mp_en`=1, the extra bit is `fmt_mp_bit`, whatever `fmt_par_en` says. Otherwise, when `fmt_par_en`=1, it is a parity bit: `fmt_par_odd`=0 makes the count of ones across the data and parity even, and `fmt_par_odd`=1 makes that count odd. When both `fmt_mp_en` and `fmt_par_en` are 0, no extra bit is sent.
- R5: The stop field is one 1 bit when `fmt_two_stop`=0 and two 1 bits when `fmt_two_stop`=1.
- R6: If `empty_flag` is 0 when the first stop bit starts, the next frame's start bit follows the last stop bit directly. In that case `end_flag` stays 0 for the whole handover.
- R7: If `empty_flag` is 1 when the first stop bit starts, `end_flag` becomes 1 during that stop bit. After the stop field the line stays at 1 until a later frame.
- R8: Clearing the empty flag through `clr_empty` also clears `end_flag`.
- R9: `irq_empty` equals `empty_flag` AND `ie_empty`. `irq_end` equals `end_flag` AND `ie_end`. Each falls as soon as its flag or its enable goes to 0.
- R10: `txd` changes only on clock edges where `bit_tick` is 1, so each bit lasts exactly one tick period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bit_tick | input | 1 | Bit-rate enable, one clock wide |
| wr_en | input | 1 | Write strobe for the holding register |
| wr_data | input | 8 | Byte to be written |
| clr_empty | input | 1 | Host handover: clears the empty and end flags |
| fmt_len7 | input | 1 | 1 selects 7 data bits |
| fmt_par_en | input | 1 | Parity bit enable |
| fmt_par_odd | input | 1 | 1 selects odd parity |
| fmt_mp_en | input | 1 | Send the address-marker bit in place of parity |
| fmt_mp_bit | input | 1 | Value of the address-marker bit |
| fmt_two_stop | input | 1 | 1 selects two stop bits |
| ie_empty | input | 1 | Enable for the data-empty interrupt |
| ie_end | input | 1 | Enable for the transmit-end interrupt |
| txd | output | 1 | Serial output line |
| empty_flag | output | 1 | Holding register free |
| end_flag | output | 1 | Transmission finished, line in mark state |
| irq_empty | output | 1 | Data-empty interrupt level |
| irq_end | output | 1 | Transmit-end interrupt level |

## Verification
The interesting collision is the stop-bit edge. On that clock the line switches to the stop level while the shift register is reloaded with the next byte and the empty flag is set again. To provoke it, the bench stages a second byte partway through a frame. It then captures both frames as one continuous bit stream. The check passes only if the second start bit lands exactly one tick after the last stop bit, and only if the end flag, sampled during that stop bit, stayed at 0. The bench also runs the same stop edge with no byte waiting, and there it expects the end flag and the mark state instead.

// File: rtl/sertx_pkg.sv
package sertx_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ARMED,
    ST_START,
    ST_DATA,
    ST_EXTRA,
    ST_STOP1,
    ST_STOP2
  } tx_state_e;

  typedef struct packed {
    logic len_short;
    logic par_en;
    logic par_odd;
    logic mp_en;
    logic mp_val;
    logic two_stop;
  } tx_fmt_t;

endpackage

// File: rtl/sertx_rst_sync.sv
module sertx_rst_sync (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) sync_q <= 2'b00;
    else         sync_q <= {sync_q[0], 1'b1};
  end

  assign srst_n = sync_q[1];
endmodule

// File: rtl/sertx_hold.sv
module sertx_hold #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              clr_empty,
  input  logic              load,
  input  logic              set_end,
  output logic [DATA_W-1:0] data_q,
  output logic              empty_q,
  output logic              end_q
);
  logic [DATA_W-1:0] data_d;
  logic              empty_d;
  logic              end_d;

  always_comb begin
    data_d  = wr_en ? wr_data : data_q;
    empty_d = empty_q;
    if (load)           empty_d = 1'b1;
    else if (clr_empty) empty_d = 1'b0;
    end_d = end_q;
    if (clr_empty)    end_d = 1'b0;
    else if (set_end) end_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q  <= '0;
      empty_q <= 1'b1;
      end_q   <= 1'b1;
    end else begin
      data_q  <= data_d;
      empty_q <= empty_d;
      end_q   <= end_d;
    end
  end

  p_load_refills_r2: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> empty_q);
  p_handover_empties_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_empty && !load) |=> !empty_q);
  p_handover_clears_end_r8: assert property (@(posedge clk) disable iff (!rst_n)
    clr_empty |=> !end_q);
  p_end_raised_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (set_end && !clr_empty) |=> end_q);
endmodule

// File: rtl/sertx_frame.sv
module sertx_frame
  import sertx_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bit_tick,
  input  logic              empty_i,
  input  logic [DATA_W-1:0] data_i,
  input  tx_fmt_t           fmt_i,
  output logic              load_o,
  output logic              set_end_o,
  output logic              txd_o
);
  localparam int IDX_W = $clog2(DATA_W + 1);
  localparam logic [IDX_W-1:0] LAST_FULL  = IDX_W'(DATA_W - 1);
  localparam logic [IDX_W-1:0] LAST_SHORT = IDX_W'(DATA_W - 2);

  tx_state_e         st_q, st_d;
  logic [IDX_W-1:0]  idx_q, idx_d, last_q, last_d;
  logic [DATA_W-1:0] shr_q, shr_d;
  logic              ext_en_q, ext_en_d, ext_val_q, ext_val_d;
  logic              pend_two_q, pend_two_d, cur_two_q, cur_two_d;
  logic              chain_q, chain_d, txd_q, txd_d;
  logic              go_stop, begin_frame;
  logic [DATA_W-1:0] masked;
  logic              par_bit;

  assign masked  = fmt_i.len_short ? {1'b0, data_i[DATA_W-2:0]} : data_i;
  assign par_bit = (^masked) ^ fmt_i.par_odd;

  always_comb begin
    st_d = st_q;        idx_d = idx_q;       last_d = last_q;
    shr_d = shr_q;      ext_en_d = ext_en_q; ext_val_d = ext_val_q;
    pend_two_d = pend_two_q; cur_two_d = cur_two_q;
    chain_d = chain_q;  txd_d = txd_q;
    load_o = 1'b0; set_end_o = 1'b0; go_stop = 1'b0; begin_frame = 1'b0;

    case (st_q)
      ST_IDLE: if (!empty_i) begin
        load_o = 1'b1;
        st_d   = ST_ARMED;
      end
      ST_ARMED: if (bit_tick) begin_frame = 1'b1;
      ST_START: if (bit_tick) begin
        st_d  = ST_DATA;
        txd_d = shr_q[0];
        shr_d = shr_q >> 1;
        idx_d = '0;
      end
      ST_DATA: if (bit_tick) begin
        if (idx_q == last_q) begin
          if (ext_en_q) begin
            st_d  = ST_EXTRA;
            txd_d = ext_val_q;
          end else begin
            go_stop = 1'b1;
          end
        end else begin
          txd_d = shr_q[0];
          shr_d = shr_q >> 1;
          idx_d = idx_q + 1'b1;
        end
      end
      ST_EXTRA: if (bit_tick) go_stop = 1'b1;
      ST_STOP1: if (bit_tick) begin
        if (cur_two_q)    st_d = ST_STOP2;
        else if (chain_q) begin_frame = 1'b1;
        else              st_d = ST_IDLE;
      end
      ST_STOP2: if (bit_tick) begin
        if (chain_q) begin_frame = 1'b1;
        else         st_d = ST_IDLE;
      end
      default: begin
        st_d  = ST_IDLE;
        txd_d = 1'b1;
      end
    endcase

    if (go_stop) begin
      st_d  = ST_STOP1;
      txd_d = 1'b1;
      if (!empty_i) begin
        load_o  = 1'b1;
        chain_d = 1'b1;
      end else begin
        set_end_o = 1'b1;
      end
    end

    if (begin_frame) begin
      st_d      = ST_START;
      txd_d     = 1'b0;
      cur_two_d = pend_two_q;
      chain_d   = 1'b0;
    end

    if (load_o) begin
      shr_d      = data_i;
      last_d     = fmt_i.len_short ? LAST_SHORT : LAST_FULL;
      ext_en_d   = fmt_i.mp_en | fmt_i.par_en;
      ext_val_d  = fmt_i.mp_en ? fmt_i.mp_val : par_bit;
      pend_two_d = fmt_i.two_stop;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= ST_IDLE;   idx_q <= '0;      last_q <= LAST_FULL;
      shr_q <= '0;       ext_en_q <= 1'b0; ext_val_q <= 1'b0;
      pend_two_q <= 1'b0; cur_two_q <= 1'b0;
      chain_q <= 1'b0;   txd_q <= 1'b1;
    end else begin
      st_q <= st_d;      idx_q <= idx_d;       last_q <= last_d;
      shr_q <= shr_d;    ext_en_q <= ext_en_d; ext_val_q <= ext_val_d;
      pend_two_q <= pend_two_d; cur_two_q <= cur_two_d;
      chain_q <= chain_d; txd_q <= txd_d;
    end
  end

  assign txd_o = txd_q;

  p_start_is_low_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_START) |-> !txd_q);
  p_idle_and_stop_high_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q inside {ST_IDLE, ST_ARMED, ST_STOP1, ST_STOP2}) |-> txd_q);
  p_line_moves_on_tick_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !bit_tick |=> $stable(txd_q));
  p_flag_outcomes_exclusive_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !(load_o && set_end_o));
endmodule

// File: rtl/sertx_top.sv
module sertx_top
  import sertx_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       bit_tick,
  input  logic       wr_en,
  input  logic [7:0] wr_data,
  input  logic       clr_empty,
  input  logic       fmt_len7,
  input  logic       fmt_par_en,
  input  logic       fmt_par_odd,
  input  logic       fmt_mp_en,
  input  logic       fmt_mp_bit,
  input  logic       fmt_two_stop,
  input  logic       ie_empty,
  input  logic       ie_end,
  output logic       txd,
  output logic       empty_flag,
  output logic       end_flag,
  output logic       irq_empty,
  output logic       irq_end
);
  localparam int DATA_W = 8;

  logic              srst_n;
  logic [DATA_W-1:0] hold_data;
  logic              load, set_end;
  tx_fmt_t           fmt;

  assign fmt = '{len_short: fmt_len7, par_en: fmt_par_en, par_odd: fmt_par_odd,
                 mp_en: fmt_mp_en, mp_val: fmt_mp_bit, two_stop: fmt_two_stop};

  sertx_rst_sync u_rst (
    .clk    (clk),
    .arst_n (rst_n),
    .srst_n (srst_n)
  );

  sertx_hold #(.DATA_W(DATA_W)) u_hold (
    .clk       (clk),
    .rst_n     (srst_n),
    .wr_en     (wr_en),
    .wr_data   (wr_data),
    .clr_empty (clr_empty),
    .load      (load),
    .set_end   (set_end),
    .data_q    (hold_data),
    .empty_q   (empty_flag),
    .end_q     (end_flag)
  );

  sertx_frame #(.DATA_W(DATA_W)) u_frame (
    .clk       (clk),
    .rst_n     (srst_n),
    .bit_tick  (bit_tick),
    .empty_i   (empty_flag),
    .data_i    (hold_data),
    .fmt_i     (fmt),
    .load_o    (load),
    .set_end_o (set_end),
    .txd_o     (txd)
  );

  assign irq_empty = empty_flag & ie_empty;
  assign irq_end   = end_flag & ie_end;
endmodule

// File: tb/sertx_top_tb_top.sv
module sertx_top_tb_top;
  localparam int TICK_DIV = 4;

  logic clk = 1'b0;
  logic rst_n;
  logic bit_tick;
  logic wr_en, clr_empty;
  logic [7:0] wr_data;
  logic fmt_len7, fmt_par_en, fmt_par_odd, fmt_mp_en, fmt_mp_bit, fmt_two_stop;
  logic ie_empty, ie_end;
  logic txd, empty_flag, end_flag, irq_empty, irq_end;

  int checks = 0;
  int errors = 0;
  int tick_cnt = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  always @(negedge clk) begin
    tick_cnt <= (tick_cnt == TICK_DIV - 1) ? 0 : tick_cnt + 1;
    bit_tick <= (tick_cnt == TICK_DIV - 2);
  end

  sertx_top dut_i (
    .clk(clk), .rst_n(rst_n), .bit_tick(bit_tick), .wr_en(wr_en), .wr_data(wr_data),
    .clr_empty(clr_empty), .fmt_len7(fmt_len7), .fmt_par_en(fmt_par_en),
    .fmt_par_odd(fmt_par_odd), .fmt_mp_en(fmt_mp_en), .fmt_mp_bit(fmt_mp_bit),
    .fmt_two_stop(fmt_two_stop), .ie_empty(ie_empty), .ie_end(ie_end), .txd(txd),
    .empty_flag(empty_flag), .end_flag(end_flag), .irq_empty(irq_empty), .irq_end(irq_end)
  );

  // {data[7:0], len7, par_en, par_odd, mp_en, mp_bit, two_stop}
  localparam logic [13:0] VEC [0:7] = '{
    {8'hA5, 6'b000000},
    {8'h07, 6'b010000},
    {8'h07, 6'b011000},
    {8'hD2, 6'b110000},
    {8'h81, 6'b010110},
    {8'h5A, 6'b000101},
    {8'hFF, 6'b100001},
    {8'h3C, 6'b011001}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic void build(input logic [13:0] v, output logic [31:0] b, output int n);
    int ones = 0;
    int nd = v[5] ? 7 : 8;
    b = '1;
    n = 0;
    b[n] = 1'b0; n++;
    for (int k = 0; k < nd; k++) begin
      b[n] = v[6 + k];
      ones += int'(v[6 + k]);
      n++;
    end
    if (v[2]) begin
      b[n] = v[1]; n++;
    end else if (v[4]) begin
      b[n] = v[3] ? ~ones[0] : ones[0]; n++;
    end
    b[n] = 1'b1; n++;
    if (v[0]) begin
      b[n] = 1'b1; n++;
    end
  endfunction

  task automatic set_fmt(input logic [13:0] v);
    {fmt_len7, fmt_par_en, fmt_par_odd, fmt_mp_en, fmt_mp_bit, fmt_two_stop} = v[5:0];
  endtask

  task automatic hand_over(input logic [7:0] d);
    @(negedge clk); wr_en = 1'b1; wr_data = d;
    @(negedge clk); wr_en = 1'b0; clr_empty = 1'b1;
    @(negedge clk); clr_empty = 1'b0;
  endtask

  task automatic capture(input int n, output logic [31:0] bits, output logic [31:0] endf,
                         output int unstable);
    int guard = 0;
    bits = '1; endf = '0; unstable = 0;
    while (txd !== 1'b0 && guard < 4000) begin
      @(negedge clk); guard++;
    end
    for (int i = 0; i < n; i++) begin
      bits[i] = txd;
      endf[i] = end_flag;
      for (int j = 1; j < TICK_DIV; j++) begin
        @(negedge clk);
        if (txd !== bits[i]) unstable++;
      end
      @(negedge clk);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] exp_b, got_b, endf, exp_b2;
    int n, n2, unst;
    rst_n = 1'b0; wr_en = 1'b0; clr_empty = 1'b0; wr_data = '0;
    ie_empty = 1'b0; ie_end = 1'b0;
    set_fmt(14'h0);
    repeat (3) @(negedge clk);
    check("R1 txd in reset", txd, 1);
    check("R1 empty in reset", empty_flag, 1);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R1 txd after reset", txd, 1);
    check("R1 flags after reset", {empty_flag, end_flag}, 2'b11);
    check("R1 irqs masked", {irq_empty, irq_end}, 2'b00);
    ie_empty = 1'b1; ie_end = 1'b1;
    @(negedge clk);
    check("R9 irqs follow enables", {irq_empty, irq_end}, 2'b11);
    ie_empty = 1'b0; ie_end = 1'b0;
    @(negedge clk);
    check("R9 irqs drop with enables", {irq_empty, irq_end}, 2'b00);

    // Table-driven frames: R3 R4 R5 R7 R2 R8 R10
    for (int v = 0; v < 8; v++) begin
      set_fmt(VEC[v]);
      build(VEC[v], exp_b, n);
      ie_empty = 1'b1;
      @(negedge clk); wr_en = 1'b1; wr_data = VEC[v][13:6];
      @(negedge clk); wr_en = 1'b0; clr_empty = 1'b1;
      @(negedge clk); clr_empty = 1'b0;
      check("R8 end cleared by handover", end_flag, 0);
      check("R9 irq_empty low while full", irq_empty, 0);
      @(negedge clk);
      check("R2 empty refilled before start", {empty_flag, txd}, 2'b11);
      check("R9 irq_empty back high", irq_empty, 1);
      capture(n, got_b, endf, unst);
      check($sformatf("R3 R4 R5 frame vector %0d", v), got_b, exp_b);
      check("R10 bit held for one tick period", unst, 0);
      check("R7 end flag during stop", endf[n - 1], 1);
      repeat (3 * TICK_DIV) @(negedge clk);
      check("R7 mark state", txd, 1);
    end

    // Back-to-back handover at the stop bit: R6
    set_fmt(14'h0);
    ie_end = 1'b1;
    build({8'h33, 6'b000000}, exp_b, n);
    build({8'hC6, 6'b000000}, exp_b2, n2);
    for (int k = 0; k < n2; k++) exp_b[n + k] = exp_b2[k];
    hand_over(8'h33);
    check("R9 irq_end drops on handover", irq_end, 0);
    @(negedge clk);
    hand_over(8'hC6);
    capture(n + n2, got_b, endf, unst);
    check("R6 two frames without gap", got_b, exp_b);
    check("R6 end flag stays low at chained stop", endf[n - 1], 0);
    check("R7 end flag after last frame", endf[n + n2 - 1], 1);
    check("R9 irq_end with enable", irq_end, 1);
    ie_end = 1'b0;
    @(negedge clk);
    check("R9 irq_end drops with enable", irq_end, 0);

    // Chained with two stop bits and 7-bit odd parity: R5 R6
    set_fmt({8'h00, 6'b111001});
    build({8'h6B, 6'b111001}, exp_b, n);
    build({8'h14, 6'b111001}, exp_b2, n2);
    for (int k = 0; k < n2; k++) exp_b[n + k] = exp_b2[k];
    hand_over(8'h6B);
    @(negedge clk);
    hand_over(8'h14);
    capture(n + n2, got_b, endf, unst);
    check("R5 R6 chained two-stop frames", got_b, exp_b);
    check("R10 chained bits held", unst, 0);

    // Reset in mid-frame returns line to idle: R1
    hand_over(8'h00);
    repeat (3 * TICK_DIV) @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    check("R1 reset mid-frame", {txd, empty_flag, end_flag}, 3'b111);
    rst_n = 1'b1;
    repeat (6) @(negedge clk);
    check("R1 idle after reset release", {txd, empty_flag, end_flag}, 3'b111);

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule